// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block collects interrupt requests from three priority groups (critical, main and peripheral) and from a 32-source DMA-engine bank behind them. It applies a per-source disable mask to each group and produces one registered status word. Each group has a pending flag and a field holding the number of its winning source. Within a group the lowest-numbered unmasked pending source wins.

The groups are chained through reserved codes. Critical code 2 means that a high-class peripheral source is pending, and main code 4 means that a low-class peripheral source is pending. In both cases software goes on to read the peripheral field. Peripheral code 0 means that the DMA bank needs service. Software then reads the bank's pending register and clears what it has handled by writing ones to it.

Access is through a single-cycle 32-bit register port: a write takes effect at the clock edge, and a read returns data combinationally from the address. Two priority registers can be written and read back, but they do not affect the status word.

Top module: `intStatusEncoder`

## Requirements
- R1: Status bit 10 is set when a critical source is pending, and bits 9:8 hold the lowest pending one. Critical inputs 0, 1 and 3 take part only when unmasked. Critical input 2 is reserved and has no effect.
- R2: Critical code 2 is pending whenever an unmasked peripheral source numbered below 4 (high class, DMA bank included) is pending. It competes with the other critical sources by the lowest-number rule.
- R3: Status bit 21 is set when a main source is pending, and bits 20:16 hold the lowest pending main source among unmasked inputs 0..16. Main input 4 is reserved and has no effect.
- R4: Main code 4 is pending whenever an unmasked peripheral source numbered 4 or above (low class) is pending. It competes with the other main sources by the lowest-number rule.
- R5: Status bit 29 is set when a peripheral source is pending, and bits 28:24 hold the lowest pending peripheral source among unmasked inputs 1..21 and source 0. Peripheral input 0 is ignored, because source 0 stands for the DMA bank.
- R6: With nothing pending, the status word is zero. A group's code field is zero whenever its flag is clear, and every status bit outside the three fields is zero.
- R7: The critical mask is at address 1. Bit n set disables critical source n. It resets to 0x0000000B, and bit 2 and bits 31:4 always read zero.
- R8: The main mask is at address 2. Bit 16-n set disables main source n. It resets to 0x00010FFF, which leaves main sources 1 to 3 enabled, and bits 31:17 always read zero.
- R9: The peripheral mask is at address 3. Bit 31-n set disables peripheral source n (n = 1..21). It resets to 0x7FFFFC00, and bits 31 and 9:0 always read zero.
- R10: The DMA pending register is at address 5 and resets to zero. Bit k is set in every cycle that DMA request k is high. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over the clear.
- R11: The DMA mask is at address 4 and resets to all ones, where bit k set disables DMA source k. Peripheral source 0 is pending exactly when a DMA pending bit is set whose mask bit is clear.
- R12: The priority registers at addresses 6 and 7 store all 32 written bits and read them back, with no effect on the status word.
- R13: The status word at address 0 is read-only, and writes to it are ignored. It shows inputs and mask contents one clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| critReq | input | 4 | Critical group requests; bit 2 is reserved |
| mainReq | input | MAIN_NUM (17) | Main group requests; bit 4 is reserved |
| periReq | input | PERI_NUM (22) | Peripheral group requests; bit 0 is reserved |
| dmaReq | input | DMA_NUM (32) | DMA bank requests, which set pending bits |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |

## Verification
A wrong mask bit or a wrong DMA pending bit shows up in the status word one clock edge after the affected request is applied. It appears as a missing group flag, as a code that names a masked source, or as a reserved forwarding code that does not agree with the peripheral field. The same faulty register can also be read back through the port in the same cycle. A broken forwarding path shows up straight away, as a critical code 2 or main code 4 with the peripheral flag clear, or as a peripheral flag with no forwarding code. The vectors place requests on both sides of every reserved code so that the winner order is exposed.

// File: rtl/intEncPkg.sv
package intEncPkg;

  localparam int DATA_W = 32;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic       wrCritMask;
    logic       wrMainMask;
    logic       wrPeriMask;
    logic       wrDmaMask;
    logic       clrDmaPend;
    logic [1:0] wrPrio;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ADDR_STATUS    = 3'd0,
    ADDR_CRIT_MASK = 3'd1,
    ADDR_MAIN_MASK = 3'd2,
    ADDR_PERI_MASK = 3'd3,
    ADDR_DMA_MASK  = 3'd4,
    ADDR_DMA_PEND  = 3'd5,
    ADDR_PRIO0     = 3'd6,
    ADDR_PRIO1     = 3'd7
  } regAddr_e;

  // index of the lowest set bit, zero when the vector is empty
  function automatic logic [CODE_W-1:0] lowestIdx(input logic [DATA_W-1:0] v);
    logic [CODE_W-1:0] idx;
    idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) idx = CODE_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/intEncCtrl.sv
module intEncCtrl
  import intEncPkg::*;
(
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  output ctrlStrobe_t strobe,
  output regAddr_e    rdSel
);

  regAddr_e addrDec;

  always_comb begin
    addrDec = regAddr_e'(regAddr);
    strobe  = '0;
    if (regWrEn) begin
      case (addrDec)
        ADDR_CRIT_MASK: strobe.wrCritMask = 1'b1;
        ADDR_MAIN_MASK: strobe.wrMainMask = 1'b1;
        ADDR_PERI_MASK: strobe.wrPeriMask = 1'b1;
        ADDR_DMA_MASK:  strobe.wrDmaMask  = 1'b1;
        ADDR_DMA_PEND:  strobe.clrDmaPend = 1'b1;
        ADDR_PRIO0:     strobe.wrPrio[0]  = 1'b1;
        ADDR_PRIO1:     strobe.wrPrio[1]  = 1'b1;
        default:        strobe            = '0;  // status is read-only
      endcase
    end
  end

  assign rdSel = addrDec;

  always_comb begin
    assert_one_strobe_R13: assert ($onehot0(strobe))
      else $error("more than one register strobe active");
  end

endmodule

// File: rtl/intEncDatapath.sv
module intEncDatapath
  import intEncPkg::*;
#(
  parameter int MAIN_NUM = 17,
  parameter int PERI_NUM = 22,
  parameter int PERI_HI  = 4,
  parameter int DMA_NUM  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  regAddr_e            rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [3:0]          critReq,
  input  logic [MAIN_NUM-1:0] mainReq,
  input  logic [PERI_NUM-1:0] periReq,
  input  logic [DMA_NUM-1:0]  dmaReq,
  output logic [DATA_W-1:0]   rdData
);

  localparam int CRIT_FWD = 2;
  localparam int MAIN_FWD = 4;
  localparam int MAIN_TOP = 16;  // main source n sits at mask bit MAIN_TOP-n
  localparam int PERI_TOP = 31;  // peripheral source n sits at mask bit PERI_TOP-n
  localparam int CRIT_FLAG = 10;
  localparam int MAIN_FLAG = 21;
  localparam int PERI_FLAG = 29;

  function automatic logic [DATA_W-1:0] mainImplCalc();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < MAIN_NUM; n++) m[MAIN_TOP-n] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] periImplCalc();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 1; n < PERI_NUM; n++) m[PERI_TOP-n] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CRIT_IMPL = 32'h0000_000B;
  localparam logic [DATA_W-1:0] MAIN_IMPL = mainImplCalc();
  localparam logic [DATA_W-1:0] PERI_IMPL = periImplCalc();
  localparam logic [DATA_W-1:0] MAIN_RST  = 32'h0001_0FFF & MAIN_IMPL;

  logic [DATA_W-1:0]  critMask, mainMask, periMask;
  logic [DMA_NUM-1:0] dmaMask, dmaPend;
  logic [DATA_W-1:0]  prioReg [2];
  logic [DATA_W-1:0]  statusQ, statusNext;

  // ---------------- mask registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critMask <= CRIT_IMPL;
      mainMask <= MAIN_RST;
      periMask <= PERI_IMPL;
      dmaMask  <= '1;
    end else begin
      if (strobe.wrCritMask) critMask <= wrData & CRIT_IMPL;
      if (strobe.wrMainMask) mainMask <= wrData & MAIN_IMPL;
      if (strobe.wrPeriMask) periMask <= wrData & PERI_IMPL;
      if (strobe.wrDmaMask)  dmaMask  <= wrData[DMA_NUM-1:0];
    end
  end

  // ---------------- DMA pending bank ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dmaPend <= '0;
    else if (strobe.clrDmaPend) dmaPend <= (dmaPend & ~wrData[DMA_NUM-1:0]) | dmaReq;
    else dmaPend <= dmaPend | dmaReq;
  end

  // ---------------- held priority registers ----------------
  for (genvar g = 0; g < 2; g++) begin : gPrio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioReg[g] <= '0;
      else if (strobe.wrPrio[g]) prioReg[g] <= wrData;
    end
  end

  // ---------------- effective request vectors ----------------
  logic [DATA_W-1:0] periVec, mainVec, critVec;
  logic dmaAny, periHiAny, periLoAny;

  assign dmaAny = |(dmaPend & ~dmaMask);

  for (genvar n = 0; n < DATA_W; n++) begin : gPeri
    if (n == 0) begin : gDma
      assign periVec[n] = dmaAny;
    end else if (n < PERI_NUM) begin : gSrc
      assign periVec[n] = periReq[n] & ~periMask[PERI_TOP-n];
    end else begin : gNone
      assign periVec[n] = 1'b0;
    end
  end

  assign periHiAny = |periVec[PERI_HI-1:0];
  assign periLoAny = |periVec[PERI_NUM-1:PERI_HI];

  for (genvar n = 0; n < DATA_W; n++) begin : gMain
    if (n == MAIN_FWD) begin : gFwd
      assign mainVec[n] = periLoAny;
    end else if (n < MAIN_NUM) begin : gSrc
      assign mainVec[n] = mainReq[n] & ~mainMask[MAIN_TOP-n];
    end else begin : gNone
      assign mainVec[n] = 1'b0;
    end
  end

  for (genvar n = 0; n < DATA_W; n++) begin : gCrit
    if (n == CRIT_FWD) begin : gFwd
      assign critVec[n] = periHiAny;
    end else if (n < 4) begin : gSrc
      assign critVec[n] = critReq[n] & ~critMask[n];
    end else begin : gNone
      assign critVec[n] = 1'b0;
    end
  end

  logic unusedReserved;
  assign unusedReserved = ^{critReq[CRIT_FWD], mainReq[MAIN_FWD], periReq[0]};

  // ---------------- status word ----------------
  logic [CODE_W-1:0] critCode, mainCode, periCode;
  logic critAny, mainAny, periAny;

  always_comb begin
    critAny  = |critVec;
    mainAny  = |mainVec;
    periAny  = |periVec;
    critCode = lowestIdx(critVec);
    mainCode = lowestIdx(mainVec);
    periCode = lowestIdx(periVec);
    statusNext = '0;
    statusNext[PERI_FLAG]     = periAny;
    statusNext[28:24]         = periCode;
    statusNext[MAIN_FLAG]     = mainAny;
    statusNext[20:16]         = mainCode;
    statusNext[CRIT_FLAG]     = critAny;
    statusNext[9:8]           = critCode[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else statusQ <= statusNext;
  end

  // ---------------- read mux ----------------
  always_comb begin
    case (rdSel)
      ADDR_STATUS:    rdData = statusQ;
      ADDR_CRIT_MASK: rdData = critMask;
      ADDR_MAIN_MASK: rdData = mainMask;
      ADDR_PERI_MASK: rdData = periMask;
      ADDR_DMA_MASK:  rdData = DATA_W'(dmaMask);
      ADDR_DMA_PEND:  rdData = DATA_W'(dmaPend);
      ADDR_PRIO0:     rdData = prioReg[0];
      default:        rdData = prioReg[1];
    endcase
  end

  // ---------------- assertions ----------------
  assert_crit_fwd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[CRIT_FLAG] && statusQ[9:8] == 2'd2) |-> statusQ[PERI_FLAG])
    else $error("critical forward code without peripheral flag");

  assert_main_fwd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[MAIN_FLAG] && statusQ[20:16] == 5'd4) |-> statusQ[PERI_FLAG])
    else $error("main forward code without peripheral flag");

  assert_idle_field_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusQ[CRIT_FLAG] |-> (statusQ[9:8] == 2'd0))
    else $error("critical field nonzero with flag clear");

  assert_dma_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDmaPend |=> ((dmaPend & $past(wrData[DMA_NUM-1:0] & ~dmaReq)) == '0))
    else $error("written-one pending bit not cleared");

  assert_dma_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaReq) |=> ((dmaPend & $past(dmaReq)) == $past(dmaReq)))
    else $error("DMA request did not set pending bit");

  assert_main_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMainMask |=> (mainMask == ($past(wrData) & MAIN_IMPL)))
    else $error("main mask write lost");

  assert_peri_fwd_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[PERI_FLAG] |-> (statusQ[CRIT_FLAG] || statusQ[MAIN_FLAG]))
    else $error("peripheral pending with no forwarding code");

endmodule

// File: rtl/intStatusEncoder.sv
module intStatusEncoder
  import intEncPkg::*;
#(
  parameter int MAIN_NUM = 17,
  parameter int PERI_NUM = 22,
  parameter int PERI_HI  = 4,
  parameter int DMA_NUM  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          critReq,
  input  logic [MAIN_NUM-1:0] mainReq,
  input  logic [PERI_NUM-1:0] periReq,
  input  logic [DMA_NUM-1:0]  dmaReq,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData
);

  ctrlStrobe_t strobe;
  regAddr_e    rdSel;

  intEncCtrl i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  intEncDatapath #(
    .MAIN_NUM (MAIN_NUM),
    .PERI_NUM (PERI_NUM),
    .PERI_HI  (PERI_HI),
    .DMA_NUM  (DMA_NUM)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .critReq (critReq),
    .mainReq (mainReq),
    .periReq (periReq),
    .dmaReq  (dmaReq),
    .rdData  (regRdData)
  );

endmodule

// File: tb/test_intStatusEncoder.sv
module test_intStatusEncoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [21:0] periReq = '0;
  logic [31:0] dmaReq = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  intStatusEncoder i_intStatusEncoder (
    .clk(clk), .rstN(rstN), .critReq(critReq), .mainReq(mainReq),
    .periReq(periReq), .dmaReq(dmaReq), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  localparam int NV = 12;
  localparam logic [3:0]  V_CRIT [NV] = '{4'h0, 4'h8, 4'hA, 4'h4, 4'h0, 4'h0,
                                          4'h0, 4'h0, 4'h0, 4'h2, 4'h1, 4'h0};
  localparam logic [16:0] V_MAIN [NV] = '{17'h0, 17'h0, 17'h0, 17'h0, 17'h220, 17'h10,
                                          17'h0, 17'h4, 17'h0, 17'h0, 17'h1, 17'h0};
  localparam logic [21:0] V_PERI [NV] = '{22'h0, 22'h0, 22'h0, 22'h0, 22'h0, 22'h0,
                                          22'h80, 22'h80, 22'h88, 22'h4, 22'h200000, 22'h1};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0, 32'h00000700, 32'h00000500, 32'h0,
                                          32'h00250000, 32'h0, 32'h27240000, 32'h27220000,
                                          32'h23240600, 32'h22000500, 32'h35200400, 32'h0};
  string vTag [NV] = '{"R6", "R1", "R1", "R1", "R3", "R3",
                       "R4", "R4", "R2", "R2", "R5", "R5"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic setIn(input logic [3:0] c, input logic [16:0] m, input logic [21:0] p);
    @(negedge clk);
    critReq = c; mainReq = m; periReq = p;
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    rdChk(3'd0, 32'h0, "R6");
    rdChk(3'd1, 32'h0000000B, "R7");
    rdChk(3'd2, 32'h00010FFF, "R8");
    rdChk(3'd3, 32'h7FFFFC00, "R9");
    rdChk(3'd4, 32'hFFFFFFFF, "R11");
    rdChk(3'd5, 32'h0, "R10");
    setIn(4'h1, 17'h2, 22'h80);          // crit 0 masked, main 1 open, peri 7 masked
    rdChk(3'd0, 32'h00210000, "R8");
    setIn(4'h0, 17'h0, 22'h0);

    // open the groups, then walk the vector table
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    for (int i = 0; i < NV; i++) begin
      setIn(V_CRIT[i], V_MAIN[i], V_PERI[i]);
      rdChk(3'd0, V_EXP[i], vTag[i]);
    end
    setIn(4'h0, 17'h0, 22'h0);

    // mask registers: unimplemented bits and disabling
    wr(3'd1, 32'hFFFFFFFF);
    rdChk(3'd1, 32'h0000000B, "R7");
    wr(3'd2, 32'hFFFFFFFF);
    rdChk(3'd2, 32'h0001FFFF, "R8");
    wr(3'd3, 32'hFFFFFFFF);
    rdChk(3'd3, 32'h7FFFFC00, "R9");
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h00000800);              // disables main source 5
    wr(3'd3, 32'h01000000);              // disables peripheral source 7
    setIn(4'h0, 17'h20, 22'h80);
    rdChk(3'd0, 32'h0, "R9");
    setIn(4'h0, 17'h220, 22'h0);
    rdChk(3'd0, 32'h00290000, "R8");
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    setIn(4'h0, 17'h0, 22'h0);

    // DMA bank
    wr(3'd4, ~32'h20);
    @(negedge clk); dmaReq = 32'h220;
    @(negedge clk); dmaReq = '0;
    @(negedge clk);
    rdChk(3'd5, 32'h00000220, "R10");
    rdChk(3'd0, 32'h20000600, "R11");
    wr(3'd5, 32'h200);
    rdChk(3'd5, 32'h00000020, "R10");
    rdChk(3'd0, 32'h20000600, "R11");
    wr(3'd5, 32'h20);
    rdChk(3'd5, 32'h0, "R10");
    rdChk(3'd0, 32'h0, "R11");
    @(negedge clk); dmaReq = 32'h200;    // masked source
    @(negedge clk); dmaReq = '0;
    @(negedge clk);
    rdChk(3'd0, 32'h0, "R11");
    wr(3'd5, 32'h200);
    // set and clear in the same cycle
    @(negedge clk);
    dmaReq = 32'h20; regWrEn = 1'b1; regAddr = 3'd5; regWrData = 32'h20;
    @(negedge clk);
    dmaReq = '0; regWrEn = 1'b0;
    rdChk(3'd5, 32'h00000020, "R10");
    wr(3'd5, 32'h20);

    // priority registers are held but ignored
    wr(3'd6, 32'hDEADBEEF);
    wr(3'd7, 32'h12345678);
    rdChk(3'd6, 32'hDEADBEEF, "R12");
    rdChk(3'd7, 32'h12345678, "R12");
    setIn(4'h0, 17'h0, 22'h88);
    rdChk(3'd0, 32'h23240600, "R12");
    setIn(4'h0, 17'h0, 22'h0);

    // status is read-only; one-edge latency
    wr(3'd0, 32'hFFFFFFFF);
    rdChk(3'd0, 32'h0, "R13");
    @(negedge clk);
    critReq = 4'h8;
    rdChk(3'd0, 32'h0, "R13");
    @(negedge clk);
    rdChk(3'd0, 32'h00000700, "R13");
    critReq = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule